// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt Flag

This block is the step timer of an audio unit that runs on the CPU clock. It counts CPU cycles from the most recent write to its mode register. It emits a strobe at each step point of the sequence, and in the four-step sequence it raises a frame interrupt flag close to the end of the sequence. Software writes the mode register to pick the four-step or the five-step sequence and to mask the interrupt. It reads the status value to see the flag, and that read also clears the flag. The block drives the interrupt request as a level for as long as the flag is up and not masked.

The flag timing is exact to the cycle. The flag can be read in the first cycle of its window. For two cycles it wins over any clearing read, so only a read made after that point clears it. A mode write is aligned to the even/odd CPU phase: a write on an even cycle restarts the count at once, and a write on an odd cycle restarts it one CPU cycle later. The clock can run faster than the CPU, and `cpu_ce` marks the cycles that count.

Top module: `frame_seq_irq`

## Requirements
- R1: After reset the status value reads 0x00, `irq` is low, no step strobe fires, the mode is four-step, the count is zero and the interrupt is not masked.
- R2: A mode write of 0x00 on an even CPU cycle (`cpu_odd`=0) restarts four-step counting, and the write cycle is cycle 0. The flag (status bit 6) reads 0 in cycle FLAG_AT-1 and reads 1 in cycle FLAG_AT (default 29831).
- R3: In cycles FLAG_AT and FLAG_AT+1 the flag setting wins over a status read. A read in either of those cycles returns 0x40, and a read four cycles later again returns 0x40.
- R4: A status read returns the flag in bit 6, with all other bits zero, and clears the flag. A read in cycle FLAG_AT+2 returns 0x40, and a read in FLAG_AT+6 returns 0x00.
- R5: `irq` is high exactly while the flag is up and the mask bit is clear. It stays high until a read or a masking write removes the flag.
- R6: A mode write with bit 6 set masks the interrupt and clears the flag. From the next cycle the status value reads 0x00 and `irq` is low, and no flag rises while the mask stays set.
- R7: A mode write with bit 7 set selects the five-step sequence, which never raises the flag. A write with bit 6 clear leaves a flag that is already up unchanged.
- R8: A mode write on an odd CPU cycle (`cpu_odd`=1) restarts the count one CPU cycle later, so the flag first reads 1 in cycle FLAG_AT+1 after that write.
- R9: The four-step count wraps to WRAP_TO after cycle FLAG_AT+1. Without a new write, the next flag appears FLAG_AT+2-WRAP_TO cycles after the first.
- R10: `step_pulse` fires for one cycle with `step_idx` 0,1,2,3. In four-step this happens at counts STEP_A, STEP_B, STEP_C and FLAG_AT. In five-step it happens at STEP_A, STEP_B, STEP_C and STEP_E, with no strobe at FLAG_AT.
- R11: Clock cycles with `cpu_ce` low change no state: the count, phase handling, flag, mask and mode all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | Marks a CPU cycle; all state advances only when it is high |
| cpu_odd | input | 1 | Phase of the current CPU cycle, 1 for odd |
| mode_wr | input | 1 | Mode register write strobe, qualified by `cpu_ce` |
| stat_rd | input | 1 | Status read strobe, qualified by `cpu_ce`; clears the flag |
| wdata | input | 8 | Mode data: bit 7 selects five-step, bit 6 masks the interrupt and clears the flag |
| rdata | output | 8 | Status value: flag in bit 6, other bits zero |
| irq | output | 1 | Level interrupt request |
| step_pulse | output | 1 | One-cycle strobe at each step point |
| step_idx | output | 2 | Index of the step point being strobed |

## Verification
The bench builds the block with FLAG_AT=40, STEP_A/B/C=10/20/30, STEP_E=50 and WRAP_TO=2. With these values one sequence lasts about forty CPU cycles rather than thirty thousand. That leaves room to place status reads on every cycle around the flag window, to follow a four-step sequence through its wrap to a second flag, and to step a five-step sequence past its last point. The window arithmetic and the phase handling do not depend on the counts, so the read-versus-set priority, odd-phase deferral and enable gaps are covered just as at the default values.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic {
    SEQ_FOUR = 1'b0,
    SEQ_FIVE = 1'b1
  } seq_mode_e;

  localparam int unsigned NUM_STEPS  = 4;
  localparam int unsigned STEP_IDX_W = $clog2(NUM_STEPS);
  localparam int unsigned STAT_BIT   = 6;
  localparam int unsigned CFG_MASK   = 6;
  localparam int unsigned CFG_FIVE   = 7;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cpu_ce,
  input  logic      cpu_odd,
  input  logic      mode_wr,
  input  logic      cfg_five,
  input  logic      cfg_mask,
  output logic      restart,
  output seq_mode_e mode_q,
  output logic      mask_q,
  output logic      flag_clr
);
  logic      pend_q, pend_d;
  seq_mode_e pmode_q, pmode_d;
  seq_mode_e mode_d;
  logic      mask_d;
  logic      wr_even;

  assign wr_even  = cpu_ce & mode_wr & ~cpu_odd;
  assign restart  = wr_even | (cpu_ce & pend_q);
  assign flag_clr = cpu_ce & mode_wr & cfg_mask;

  always_comb begin
    pend_d  = pend_q;
    pmode_d = pmode_q;
    mode_d  = mode_q;
    mask_d  = mask_q;
    if (cpu_ce) begin
      pend_d = mode_wr & cpu_odd;
      if (mode_wr) begin
        mask_d = cfg_mask;
        if (cpu_odd) pmode_d = seq_mode_e'(cfg_five);
      end
      if (wr_even)     mode_d = seq_mode_e'(cfg_five);
      else if (pend_q) mode_d = pmode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pmode_q <= SEQ_FOUR;
      mode_q  <= SEQ_FOUR;
      mask_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pmode_q <= pmode_d;
      mode_q  <= mode_d;
      mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
  import fseq_pkg::*;
#(
  parameter int unsigned FLAG_AT = 29831,
  parameter int unsigned STEP_A  = 7457,
  parameter int unsigned STEP_B  = 14913,
  parameter int unsigned STEP_C  = 22371,
  parameter int unsigned STEP_E  = 37281,
  parameter int unsigned WRAP_TO = 3,
  parameter int unsigned CW      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_ce,
  input  logic                  restart,
  input  seq_mode_e             mode_q,
  output logic [CW-1:0]         cnt_q,
  output logic                  set_win,
  output logic                  step_pulse,
  output logic [STEP_IDX_W-1:0] step_idx
);
  localparam int unsigned PT4 [NUM_STEPS] = '{STEP_A, STEP_B, STEP_C, FLAG_AT};
  localparam int unsigned PT5 [NUM_STEPS] = '{STEP_A, STEP_B, STEP_C, STEP_E};

  logic [CW-1:0]        cnt_d;
  logic [CW-1:0]        last_c;
  logic [NUM_STEPS-1:0] hit;

  assign last_c  = (mode_q == SEQ_FIVE) ? CW'(STEP_E) : CW'(FLAG_AT + 1);
  assign set_win = (mode_q == SEQ_FOUR) &&
                   ((cnt_q == CW'(FLAG_AT)) || (cnt_q == CW'(FLAG_AT + 1)));

  always_comb begin
    cnt_d = cnt_q;
    if (cpu_ce) begin
      if (restart)              cnt_d = CW'(1);
      else if (cnt_q == last_c) cnt_d = CW'(WRAP_TO);
      else                      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_point
    assign hit[g] = (cnt_q == ((mode_q == SEQ_FIVE) ? CW'(PT5[g]) : CW'(PT4[g])));
  end

  always_comb begin
    step_idx = '0;
    for (int i = 0; i < NUM_STEPS; i++) begin
      if (hit[i]) step_idx = STEP_IDX_W'(i);
    end
  end

  assign step_pulse = cpu_ce & (|hit);
endmodule

// File: rtl/fseq_flag.sv
module fseq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ce,
  input  logic stat_rd,
  input  logic flag_clr,
  input  logic set_win,
  input  logic mask_q,
  output logic flag_q,
  output logic flag_vis,
  output logic irq
);
  logic flag_d;
  logic set_live;

  assign set_live = set_win & ~mask_q;

  always_comb begin
    flag_d = flag_q;
    if (flag_clr)                  flag_d = 1'b0;
    else if (cpu_ce && set_live)   flag_d = 1'b1;
    else if (cpu_ce && stat_rd)    flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_vis = flag_q | set_live;
  assign irq      = flag_vis & ~mask_q;
endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq #(
  parameter int unsigned FLAG_AT = 29831,
  parameter int unsigned STEP_A  = 7457,
  parameter int unsigned STEP_B  = 14913,
  parameter int unsigned STEP_C  = 22371,
  parameter int unsigned STEP_E  = 37281,
  parameter int unsigned WRAP_TO = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_ce,
  input  logic       cpu_odd,
  input  logic       mode_wr,
  input  logic       stat_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       step_pulse,
  output logic [1:0] step_idx
);
  import fseq_pkg::*;

  localparam int unsigned MAXV = (STEP_E > FLAG_AT + 1) ? STEP_E : FLAG_AT + 1;
  localparam int unsigned CW   = $clog2(MAXV + 1);

  logic          restart;
  seq_mode_e     mode_q;
  logic          mask_q;
  logic          flag_clr;
  logic [CW-1:0] cnt_q;
  logic          set_win;
  logic          flag_q;
  logic          flag_vis;
  logic          unused_wbits;

  assign unused_wbits = ^wdata[5:0];

  fseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ce   (cpu_ce),
    .cpu_odd  (cpu_odd),
    .mode_wr  (mode_wr),
    .cfg_five (wdata[CFG_FIVE]),
    .cfg_mask (wdata[CFG_MASK]),
    .restart  (restart),
    .mode_q   (mode_q),
    .mask_q   (mask_q),
    .flag_clr (flag_clr)
  );

  fseq_timer #(
    .FLAG_AT (FLAG_AT),
    .STEP_A  (STEP_A),
    .STEP_B  (STEP_B),
    .STEP_C  (STEP_C),
    .STEP_E  (STEP_E),
    .WRAP_TO (WRAP_TO),
    .CW      (CW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ce     (cpu_ce),
    .restart    (restart),
    .mode_q     (mode_q),
    .cnt_q      (cnt_q),
    .set_win    (set_win),
    .step_pulse (step_pulse),
    .step_idx   (step_idx)
  );

  fseq_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ce   (cpu_ce),
    .stat_rd  (stat_rd),
    .flag_clr (flag_clr),
    .set_win  (set_win),
    .mask_q   (mask_q),
    .flag_q   (flag_q),
    .flag_vis (flag_vis),
    .irq      (irq)
  );

  always_comb begin
    rdata           = 8'h00;
    rdata[STAT_BIT] = flag_vis;
  end
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ce,
  input logic          mode_wr,
  input logic          stat_rd,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          irq,
  input logic          step_pulse,
  input logic          restart,
  input logic          set_win,
  input logic          flag_q,
  input logic          mask_q,
  input logic          five_q,
  input logic [CW-1:0] cnt_q
);
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && restart) |=> (cnt_q == CW'(1)));

  p_win_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && set_win && !mask_q && !(mode_wr && wdata[6])) |=> flag_q);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && stat_rd && !mode_wr && !set_win) |=> !flag_q);

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cpu_ce) |=> irq);

  p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && mode_wr && wdata[6]) |=> (rdata == 8'h00 && !irq));

  p_five_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    five_q |-> !set_win);

  p_step_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> cpu_ce);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |=> ($stable(cnt_q) && $stable(flag_q) && $stable(mask_q)));
endmodule

bind frame_seq_irq fseq_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_ce     (cpu_ce),
  .mode_wr    (mode_wr),
  .stat_rd    (stat_rd),
  .wdata      (wdata),
  .rdata      (rdata),
  .irq        (irq),
  .step_pulse (step_pulse),
  .restart    (restart),
  .set_win    (set_win),
  .flag_q     (flag_q),
  .mask_q     (mask_q),
  .five_q     (mode_q == fseq_pkg::SEQ_FIVE),
  .cnt_q      (cnt_q)
);

// File: tb/frame_seq_irq_tb.sv
module frame_seq_irq_tb_top;
  localparam int W  = 40;
  localparam int SA = 10;
  localparam int SB = 20;
  localparam int SC = 30;
  localparam int SE = 50;
  localparam int WT = 2;

  logic       clk;
  logic       rst_n;
  logic       cpu_ce, cpu_odd, mode_wr, stat_rd;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq, step_pulse;
  logic [1:0] step_idx;

  int checks = 0;
  int errors = 0;
  int rel    = 0;
  int s_rel  = 0;
  logic       ph = 1'b0;
  logic [7:0] s_rd;
  logic       s_irq, s_sp;
  logic [1:0] s_idx;
  logic [7:0] v;

  frame_seq_irq #(
    .FLAG_AT (W),  .STEP_A (SA), .STEP_B (SB),
    .STEP_C  (SC), .STEP_E (SE), .WRAP_TO (WT)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .cpu_ce (cpu_ce), .cpu_odd (cpu_odd),
    .mode_wr (mode_wr), .stat_rd (stat_rd), .wdata (wdata),
    .rdata (rdata), .irq (irq), .step_pulse (step_pulse), .step_idx (step_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [7:0] d, input bit en = 1'b1);
    @(negedge clk);
    cpu_ce = en; mode_wr = w; stat_rd = r; wdata = d; cpu_odd = ph;
    #2;
    s_rd = rdata; s_irq = irq; s_sp = step_pulse; s_idx = step_idx; s_rel = rel;
    if (en) begin
      ph = ~ph;
      rel++;
    end
  endtask

  task automatic idle_to(input int k);
    while (rel < k) cyc(1'b0, 1'b0, 8'h00);
  endtask

  task automatic read_at(input int k, output logic [7:0] val);
    idle_to(k);
    cyc(1'b0, 1'b1, 8'h00);
    val = s_rd;
  endtask

  task automatic start_mode(input logic [7:0] m);
    cyc(1'b1, 1'b0, 8'h40);
    if (ph) cyc(1'b0, 1'b0, 8'h00);
    rel = 0;
    cyc(1'b1, 1'b0, m);
  endtask

  task automatic t_reset_r1();
    chk("R1 status", s_rd, 0);
    chk("R1 irq", s_irq, 0);
    chk("R1 strobe", s_sp, 0);
  endtask

  task automatic t_pair(input int a, input int ea, input int eb, input string req);
    logic [7:0] x;
    start_mode(8'h00);
    read_at(a, x);
    chk(req, x, ea);
    read_at(a + 4, x);
    chk(req, x, eb);
  endtask

  task automatic t_irq_r5();
    start_mode(8'h00);
    idle_to(W - 1); cyc(1'b0, 1'b0, 8'h00);
    chk("R5 irq before window", s_irq, 0);
    cyc(1'b0, 1'b0, 8'h00);
    chk("R5 irq in window", s_irq, 1);
    idle_to(W + 2); cyc(1'b0, 1'b1, 8'h00);
    chk("R5 irq held until read", s_irq, 1);
    cyc(1'b0, 1'b0, 8'h00);
    chk("R5 irq after read", s_irq, 0);
  endtask

  task automatic t_mask_r6();
    logic [7:0] x;
    start_mode(8'h00);
    idle_to(W + 3); cyc(1'b0, 1'b0, 8'h00);
    chk("R6 flag up before mask", s_irq, 1);
    cyc(1'b1, 1'b0, 8'h40);
    cyc(1'b0, 1'b0, 8'h00);
    chk("R6 status after mask", s_rd, 0);
    chk("R6 irq after mask", s_irq, 0);
    if (ph) cyc(1'b0, 1'b0, 8'h00);
    rel = 0;
    cyc(1'b1, 1'b0, 8'h40);
    idle_to(W); cyc(1'b0, 1'b0, 8'h00);
    chk("R6 irq masked in window", s_irq, 0);
    read_at(W + 3, x);
    chk("R6 no flag while masked", x, 0);
  endtask

  task automatic t_five_r7();
    logic [7:0] x;
    start_mode(8'h80);
    read_at(W + 1, x);
    chk("R7 five-step window", x, 0);
    read_at(W + 5, x);
    chk("R7 five-step later", x, 0);
    start_mode(8'h00);
    idle_to(W + 3);
    cyc(1'b1, 1'b0, 8'h80);
    read_at(rel + 2, x);
    chk("R7 flag kept by bit7 write", x, 8'h40);
  endtask

  task automatic t_odd_r8();
    logic [7:0] x;
    cyc(1'b1, 1'b0, 8'h40);
    if (!ph) cyc(1'b0, 1'b0, 8'h00);
    rel = 0;
    cyc(1'b1, 1'b0, 8'h00);
    read_at(W, x);
    chk("R8 odd write not yet", x, 0);
    read_at(W + 1, x);
    chk("R8 odd write one late", x, 8'h40);
  endtask

  task automatic t_wrap_r9();
    logic [7:0] x;
    int p;
    p = W + 2 - WT;
    start_mode(8'h00);
    read_at(W + 2, x);
    chk("R9 first flag", x, 8'h40);
    read_at(W + p - 1, x);
    chk("R9 before second flag", x, 0);
    read_at(W + p, x);
    chk("R9 second flag", x, 8'h40);
  endtask

  task automatic t_steps_r10(input bit five);
    int bad;
    int hits;
    int e;
    bad = 0; hits = 0;
    start_mode(five ? 8'h80 : 8'h00);
    while (rel <= (five ? SE + 3 : W + 5)) begin
      cyc(1'b0, 1'b0, 8'h00);
      e = -1;
      if (s_rel == SA) e = 0;
      if (s_rel == SB) e = 1;
      if (s_rel == SC) e = 2;
      if (!five && s_rel == W)  e = 3;
      if (five && s_rel == SE)  e = 3;
      if (e < 0) begin
        if (s_sp) bad++;
      end else begin
        hits++;
        if (!s_sp || s_idx != 2'(e)) bad++;
      end
    end
    chk(five ? "R10 five-step strobes" : "R10 four-step strobes", bad, 0);
    chk("R10 strobe count", hits, 4);
  endtask

  task automatic t_gap_r11();
    logic [7:0] x;
    start_mode(8'h00);
    idle_to(15);
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0);
    read_at(W - 1, x);
    chk("R11 gap shifts flag", x, 0);
    read_at(W, x);
    chk("R11 flag after gap", x, 8'h40);
  endtask

  initial begin
    logic [7:0] x;
    rst_n = 1'b0; cpu_ce = 1'b0; cpu_odd = 1'b0;
    mode_wr = 1'b0; stat_rd = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    s_rd = rdata; s_irq = irq; s_sp = step_pulse;
    t_reset_r1();
    @(negedge clk); rst_n = 1'b1;
    read_at(rel + 1, x);
    chk("R1 status after release", x, 0);
    t_pair(W - 1, 0, 8'h40, "R2 first visible cycle");
    t_pair(W, 8'h40, 8'h40, "R3 read in first set cycle");
    t_pair(W + 1, 8'h40, 8'h40, "R3 read in second set cycle");
    t_pair(W + 2, 8'h40, 0, "R4 read after set window");
    t_irq_r5();
    t_mask_r6();
    t_five_r7();
    t_odd_r8();
    t_wrap_r9();
    t_steps_r10(1'b0);
    t_steps_r10(1'b1);
    t_gap_r11();
    cyc(1'b0, 1'b0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule